// File: doc/BRIEF.md
# Performance Monitoring Counter Bank with Forced-Increment Test

This block keeps four performance-monitoring counters for a receive datapath. Two of them count block errors and ATM cells. The other two count line coding violations and far-end block errors. In normal operation each counter advances by one on every clock cycle in which its own event strobe is high. A counter that reaches its top value stays there.

A latch (snapshot) request closes the current interval. It copies all live counters into holding registers and restarts the live counters in the same cycle. Software then reads the frozen values one at a time through a select input.

A test bit, written through a small configuration port, lets software exercise the counters without real error conditions. While the bit is set, the real strobes are ignored and the counters advance from the receive clock instead. The block-error and cell counters advance once every two rising edges. The coding-violation and far-end counters advance once every four rising edges. Reset clears the test bit.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every live counter and every holding register reads zero.
- R2: With the test bit clear, counter k increases by exactly one at each rising edge where evt_i[k] is high. Bit 0 is block errors, bit 1 is ATM cells, bit 2 is coding violations and bit 3 is far-end block errors. Each counter is independent of the others.
- R3: With the test bit set, the block-error and cell counters (indices 0 and 1) increase by one on every second rising edge after the edge that sets the bit.
- R4: With the test bit set, the coding-violation and far-end counters (indices 2 and 3) increase by one on every fourth rising edge after the edge that sets the bit.
- R5: With the test bit set, evt_i has no effect on any counter.
- R6: A write with cfg_we_i high loads cfg_test_i into the test bit at that edge. Reset clears the bit, so counting from events is the default after reset.
- R7: A counter at its all-ones value holds that value rather than wrapping.
- R8: At an edge where snap_i is high, every holding register takes its counter's value from before that edge. Each live counter restarts at 1 if it has an increment in that cycle, and at 0 otherwise. Holding registers do not change at any other edge.
- R9: The divide-by-two and divide-by-four sequences restart from zero each time the test bit goes from clear to set.
- R10: rd_data_o shows the holding register selected by rd_sel_i, using the index encoding of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 4 | Event strobes, one per counter (index encoding as in R2) |
| cfg_we_i | input | 1 | Write strobe for the test bit |
| cfg_test_i | input | 1 | Value written into the test bit |
| snap_i | input | 1 | Latch request: copy counters to holding registers and restart them |
| rd_sel_i | input | 2 | Holding register select |
| rd_data_o | output | CNT_W | Selected holding register value |

## Verification
The assertions check several properties on every cycle. A counter moves by at most one per cycle and never wraps from all-ones. A latch leaves each live counter at zero or one. Holding registers change only on a latch. Each prescaler tick is isolated, and the prescaler sits at zero in the cycle the test bit rises. Some behaviour only the bench scenarios can show. These are the exact two-to-one and four-to-one spacing measured against a snapshot, the masking of strobes in test mode, and the restart after a re-entry into test mode. They also include reset clearing the test bit and the attribution of an event in the latch cycle to the new interval.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int NUM_CNT = 4;
  localparam int SEL_W   = $clog2(NUM_CNT);

  typedef enum logic [SEL_W-1:0] {
    CNT_BLOCK_ERR = 2'd0,
    CNT_CELL      = 2'd1,
    CNT_CODE_VIOL = 2'd2,
    CNT_FAR_END   = 2'd3
  } cnt_id_e;

  // Counters in the slow class advance every fourth edge in test mode.
  function automatic logic is_slow_class(input int idx);
    return (idx == int'(CNT_CODE_VIOL)) || (idx == int'(CNT_FAR_END));
  endfunction

endpackage

// File: rtl/pmc_prescaler.sv
module pmc_prescaler (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick2_o,
  output logic tick4_o
);

  logic [1:0] pre_q;
  logic [1:0] pre_d;

  always_comb begin
    if (en_i) pre_d = pre_q + 2'd1;
    else      pre_d = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= 2'd0;
    else        pre_q <= pre_d;
  end

  assign tick2_o = en_i & pre_q[0];
  assign tick4_o = en_i & (pre_q == 2'd3);

  AST_TICK2_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick2_o |=> !tick2_o); // R3
  AST_TICK4_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick4_o |=> !tick4_o); // R4
  AST_RESTART_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> (pre_q == 2'd0)); // R9

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_top;

  assign at_top = (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = inc_i ? ONE : '0;
    end else if (inc_i && !at_top) begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && at_top) |=> (cnt_q == TOP)); // R7
  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE))); // R2
  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q <= ONE)); // R8

endmodule

// File: rtl/pmc_hold.sv
module pmc_hold #(
  parameter int N     = 4,
  parameter int W     = 16,
  parameter int SEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snap_i,
  input  logic [N-1:0][W-1:0] live_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [W-1:0]        rd_data_o
);

  logic [N-1:0][W-1:0] hold_q;
  logic [N-1:0][W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (snap_i) hold_d = live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SEL_W'(i)) rd_data_o = hold_q[i];
    end
  end

  AST_HOLD_ONLY_ON_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> $stable(hold_q)); // R8

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               cfg_we_i,
  input  logic               cfg_test_i,
  input  logic               snap_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [CNT_W-1:0]   rd_data_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // Test-mode control bit.
  logic test_q;
  logic test_d;

  always_comb begin
    test_d = test_q;
    if (cfg_we_i) test_d = cfg_test_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) test_q <= 1'b0;
    else            test_q <= test_d;
  end

  // Internal increment clocks.
  logic tick2;
  logic tick4;

  pmc_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (test_q),
    .tick2_o (tick2),
    .tick4_o (tick4)
  );

  // Counter lanes.
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] live;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
    logic forced;

    if (is_slow_class(g)) begin : g_slow
      assign forced = tick4;
    end else begin : g_fast
      assign forced = tick2;
    end

    assign inc[g] = test_q ? forced : evt_i[g];

    pmc_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .inc_i (inc[g]),
      .clr_i (snap_i),
      .cnt_o (live[g])
    );
  end

  pmc_hold #(.N(NUM_CNT), .W(CNT_W), .SEL_W(SEL_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .snap_i    (snap_i),
    .live_i    (live),
    .sel_i     (rd_sel_i),
    .rd_data_o (rd_data_o)
  );

  AST_TEST_NO_STRAY_INC: assert property (@(posedge clk) disable iff (!rst_int_n)
    (test_q && !tick2) |-> (inc == '0)); // R5
  AST_TEST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(test_q) |-> (inc == '0)); // R9

endmodule

// File: tb/pmc_bank_test.sv
`timescale 1ns/1ps
module pmc_bank_test;

  localparam int W   = 8;
  localparam int N   = 4;
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] evt_i;
  logic         cfg_we_i;
  logic         cfg_test_i;
  logic         snap_i;
  logic [1:0]   rd_sel_i;
  logic [W-1:0] rd_data_o;

  pmc_bank #(.CNT_W(W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_test_i (cfg_test_i),
    .snap_i     (snap_i),
    .rd_sel_i   (rd_sel_i),
    .rd_data_o  (rd_data_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    sel;
    int    exp;
    string req;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;

  // Reference model state.
  int m_live[N];
  bit m_test;
  int m_edges;

  // Monitor: pops expected items and compares against the read port.
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        rd_sel_i = it.sel[1:0];
        #0.2;
        checks++;
        if (int'(rd_data_o) != it.exp) begin
          errors++;
          $display("FAIL %s counter=%0d actual=%0d expected=%0d",
                   it.req, it.sel, rd_data_o, it.exp);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  function automatic bit slow(input int k);
    return k >= 2;
  endfunction

  // One clock cycle of stimulus plus the model update for that edge.
  task automatic step(input logic [N-1:0] e, input bit lat, input bit we,
                      input bit tst, input string tag);
    bit inc[N];
    @(negedge clk);
    evt_i      = e;
    snap_i     = lat;
    cfg_we_i   = we;
    cfg_test_i = tst;
    if (m_test) m_edges++;
    for (int k = 0; k < N; k++) begin
      if (m_test) inc[k] = (m_edges % (slow(k) ? 4 : 2)) == 0;
      else        inc[k] = e[k];
    end
    for (int k = 0; k < N; k++) begin
      if (lat) begin
        item_t it;
        it.sel = k;
        it.exp = m_live[k];
        it.req = tag;
        q.push_back(it);
        m_live[k] = inc[k] ? 1 : 0;
      end else if (inc[k] && m_live[k] < TOP) begin
        m_live[k]++;
      end
    end
    if (we) begin
      if (tst && !m_test) m_edges = 0;
      m_test = tst;
    end
    @(posedge clk);
    #1;
    if (lat) begin
      -> chk_ev;
      wait (q.size() == 0);
    end
  endtask

  task automatic idle(input logic [N-1:0] e, input int n);
    for (int i = 0; i < n; i++) step(e, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    evt_i = '0; snap_i = 1'b0; cfg_we_i = 1'b0; cfg_test_i = 1'b0;
    for (int k = 0; k < N; k++) m_live[k] = 0;
    m_test = 1'b0;
    m_edges = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    evt_i = '0; snap_i = 1'b0; cfg_we_i = 1'b0; cfg_test_i = 1'b0; rd_sel_i = '0;
    do_reset();

    // R1 R10: reset state through every select value
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R1 R10");

    // R2: independent event counting, several patterns
    idle(4'b0001, 10);
    idle(4'b1010, 5);
    idle(4'b0110, 7);
    // R8: event in latch cycle belongs to the new interval
    step(4'b1001, 1'b1, 1'b0, 1'b0, "R2 R10");
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R8");

    // R3 R4 R5: forced increments with strobes held high
    step(4'b1111, 1'b0, 1'b1, 1'b1, "");
    idle(4'b1111, 13);
    step(4'b1111, 1'b1, 1'b0, 1'b0, "R3 R4 R5");
    idle(4'b1111, 6);
    step(4'b1111, 1'b1, 1'b0, 1'b0, "R3 R4 R8");

    // R9: leave and re-enter test mode, sequence restarts
    step(4'b0000, 1'b0, 1'b1, 1'b0, "");
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R9");
    step(4'b0000, 1'b0, 1'b1, 1'b1, "");
    step(4'b0000, 1'b0, 1'b1, 1'b0, "");
    step(4'b0000, 1'b0, 1'b1, 1'b1, "");
    idle(4'b0000, 5);
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R9");

    // R7: saturation in test mode
    idle(4'b0000, 600);
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R7");
    step(4'b0000, 1'b0, 1'b1, 1'b0, "");
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R6");

    // R7: saturation from events
    idle(4'b1111, 300);
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R7");

    // R6: reset clears test mode, events count again
    step(4'b0000, 1'b0, 1'b1, 1'b1, "");
    idle(4'b0000, 4);
    do_reset();
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R1");
    idle(4'b0011, 6);
    step(4'b0000, 1'b1, 1'b0, 1'b0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule